// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Sequencer

This block produces, once per reference cycle, the integer division value that a feedback divider uses next, so that the average of those values equals INT + FRAC/DEN exactly. It runs on the reference-rate clock. Each enabled cycle it emits a small signed offset from INT and the full divide value INT + offset, together with a valid strobe.

A load strobe captures INT, FRAC, DEN and a noise-shaping order. It also clears all accumulated state, so every new ratio starts from a zero residue. The first order toggles between two neighbouring integers. The second and third orders are cascades of modulo-DEN accumulators whose carries are combined through difference networks. This pushes the quantisation error toward half the reference rate, at the cost of a wider spread of divide values.

A comparator flags any configuration in which INT plus the most negative offset of the selected order would drop below the divider's minimum continuous ratio.

Top module: `frac_n_seq_mod`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and offset_o is 0 until the first enabled step.
- R2: With order code 0 (first order), offset_o is 0 or 1, and after n enabled steps since a load the offsets sum to floor(n·FRAC/DEN).
- R3: With INT=900, FRAC=1, DEN=5 and order 0, every five consecutive steps give four 900s and one 901 on div_o, and the pattern repeats with period 5.
- R4: With order code 1 (second order), every valid offset lies in −1..+2.
- R5: With order code 2 or 3 (third order), every valid offset lies in −3..+4.
- R6: For orders 2 and 3, after n enabled steps since a load, the offset sum S satisfies |DEN·S − n·FRAC| ≤ 2·DEN, so the long-run mean is exactly FRAC/DEN.
- R7: A step is taken on a rising edge with en_i=1 and cfg_ld_i=0, and valid_o is 1 for the cycle after it. With en_i=0, valid_o is 0, offset_o keeps its value, and the sequence resumes where it paused.
- R8: A rising edge with cfg_ld_i=1 loads the configuration and clears all state. In the next cycle valid_o=0 and offset_o=0, and it takes precedence over en_i.
- R9: div_o equals the loaded INT plus the sign-extended offset_o.
- R10: min_viol_o is 1 exactly when the loaded INT plus the most negative offset of the loaded order (0, −1, −3 for first, second, third) is below MIN_RATIO (default 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the sequence this cycle |
| cfg_ld_i | input | 1 | Load configuration and clear state |
| order_i | input | 2 | Order: 0 first, 1 second, 2/3 third |
| int_i | input | INT_W | Integer part of the ratio |
| frac_i | input | FRAC_W | Fraction numerator, below den_i |
| den_i | input | FRAC_W | Fraction denominator, at least 1 |
| offset_o | output | 4 | Signed offset from INT |
| div_o | output | INT_W+1 | Divide value INT + offset |
| valid_o | output | 1 | New value produced by the last step |
| min_viol_o | output | 1 | Configured range reaches below MIN_RATIO |

## Verification
Some properties are checked on every cycle. The assertions keep the offset within the span of the loaded order. They tie valid_o to the previous cycle's enable and load. They hold the offset while paused and force a clean output after a load.

Other properties need a run of cycles and are shown only by the bench scenarios. These are the exact cumulative count of the first order, the bounded drift of the higher orders against n·FRAC/DEN, the four-and-one pattern for a one-fifth fraction, and the minimum-ratio flag across order and INT corners.

// File: rtl/frac_n_pkg.sv
package frac_n_pkg;
  localparam int NSTAGE = 3;
  localparam int OFS_W  = 4;

  typedef enum logic [1:0] {
    ORD_FIRST  = 2'd0,
    ORD_SECOND = 2'd1,
    ORD_THIRD  = 2'd2,
    ORD_THIRD2 = 2'd3
  } order_e;

  function automatic logic signed [OFS_W-1:0] min_offset(order_e o);
    case (o)
      ORD_FIRST:  return 4'sd0;
      ORD_SECOND: return -4'sd1;
      default:    return -4'sd3;
    endcase
  endfunction
endpackage

// File: rtl/mod_accum_stage.sv
module mod_accum_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, in_i};
    carry_o = (sum >= {1'b0, den_i});
    res_o   = carry_o ? W'(sum - {1'b0, den_i}) : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= res_o;
  end
endmodule

// File: rtl/mash_combine.sv
module mash_combine
  import frac_n_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    step_i,
  input  logic [NSTAGE-1:0]       carry_i,
  input  order_e                  order_i,
  output logic signed [OFS_W-1:0] offset_o
);
  logic c2_d_q, c3_d_q, c3_dd_q;
  logic signed [OFS_W-1:0] t1, t2, t3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_d_q  <= 1'b0;
      c3_d_q  <= 1'b0;
      c3_dd_q <= 1'b0;
    end else if (clr_i) begin
      c2_d_q  <= 1'b0;
      c3_d_q  <= 1'b0;
      c3_dd_q <= 1'b0;
    end else if (step_i) begin
      c2_d_q  <= carry_i[1];
      c3_d_q  <= carry_i[2];
      c3_dd_q <= c3_d_q;
    end
  end

  // first, first difference, second difference of the three carries
  always_comb begin
    t1 = $signed({3'b000, carry_i[0]});
    t2 = $signed({3'b000, carry_i[1]}) - $signed({3'b000, c2_d_q});
    t3 = $signed({3'b000, carry_i[2]}) - $signed({2'b00, c3_d_q, 1'b0})
       + $signed({3'b000, c3_dd_q});
    case (order_i)
      ORD_FIRST:  offset_o = t1;
      ORD_SECOND: offset_o = t1 + t2;
      default:    offset_o = t1 + t2 + t3;
    endcase
  end
endmodule

// File: rtl/min_ratio_chk.sv
module min_ratio_chk
  import frac_n_pkg::*;
#(
  parameter int INT_W     = 12,
  parameter int MIN_RATIO = 12
) (
  input  logic [INT_W-1:0] int_i,
  input  order_e           order_i,
  output logic             viol_o
);
  localparam int SW = INT_W + 2;
  logic signed [OFS_W-1:0] mo;
  logic signed [SW-1:0]    lo;

  always_comb begin
    mo     = min_offset(order_i);
    lo     = $signed({2'b00, int_i}) + $signed({{(SW-OFS_W){mo[OFS_W-1]}}, mo});
    viol_o = (lo < $signed(SW'(MIN_RATIO)));
  end
endmodule

// File: rtl/frac_n_seq_mod.sv
module frac_n_seq_mod
  import frac_n_pkg::*;
#(
  parameter int INT_W     = 12,
  parameter int FRAC_W    = 16,
  parameter int MIN_RATIO = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    cfg_ld_i,
  input  logic [1:0]              order_i,
  input  logic [INT_W-1:0]        int_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic [FRAC_W-1:0]       den_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic [INT_W:0]          div_o,
  output logic                    valid_o,
  output logic                    min_viol_o
);
  localparam int DIV_W = INT_W + 1;

  order_e             order_q;
  logic [INT_W-1:0]   int_q;
  logic [FRAC_W-1:0]  frac_q, den_q;
  logic               step;
  logic [FRAC_W-1:0]  res [NSTAGE];
  logic [NSTAGE-1:0]  carry;
  logic signed [OFS_W-1:0] ofs_next, ofs_q;
  logic               valid_q;

  assign step = en_i & ~cfg_ld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q <= ORD_FIRST;
      int_q   <= '0;
      frac_q  <= '0;
      den_q   <= FRAC_W'(1);
    end else if (cfg_ld_i) begin
      order_q <= order_e'(order_i);
      int_q   <= int_i;
      frac_q  <= frac_i;
      den_q   <= den_i;
    end
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic [FRAC_W-1:0] stage_in;
    if (k == 0) begin : g_head
      assign stage_in = frac_q;
    end else begin : g_tail
      assign stage_in = res[k-1];
    end
    mod_accum_stage #(.W(FRAC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cfg_ld_i),
      .step_i  (step),
      .in_i    (stage_in),
      .den_i   (den_q),
      .res_o   (res[k]),
      .carry_o (carry[k])
    );
  end

  mash_combine u_comb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_ld_i),
    .step_i   (step),
    .carry_i  (carry),
    .order_i  (order_q),
    .offset_o (ofs_next)
  );

  min_ratio_chk #(.INT_W(INT_W), .MIN_RATIO(MIN_RATIO)) u_min (
    .int_i   (int_q),
    .order_i (order_q),
    .viol_o  (min_viol_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step;
      if (cfg_ld_i)  ofs_q <= '0;
      else if (step) ofs_q <= ofs_next;
    end
  end

  assign offset_o = ofs_q;
  assign valid_o  = valid_q;
  assign div_o    = {1'b0, int_q} + {{(DIV_W-OFS_W){ofs_q[OFS_W-1]}}, ofs_q};
endmodule

// File: rtl/frac_n_seq_mod_chk.sv
module frac_n_seq_mod_chk (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cfg_ld_i,
  input logic [1:0]        order_q,
  input logic signed [3:0] offset_o,
  input logic              valid_o
);
  p_first_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && order_q == 2'd0) |-> (offset_o >= 4'sd0 && offset_o <= 4'sd1));

  p_second_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && order_q == 2'd1) |-> (offset_o >= -4'sd1 && offset_o <= 4'sd2));

  p_third_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && order_q[1]) |-> (offset_o >= -4'sd3 && offset_o <= 4'sd4));

  p_step_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !cfg_ld_i) |=> valid_o);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cfg_ld_i) |=> (!valid_o && $stable(offset_o)));

  p_load_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ld_i |=> (!valid_o && offset_o == 4'sd0));
endmodule

bind frac_n_seq_mod frac_n_seq_mod_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .cfg_ld_i (cfg_ld_i),
  .order_q  (order_q),
  .offset_o (offset_o),
  .valid_o  (valid_o)
);

// File: tb/frac_n_seq_mod_tb.sv
module frac_n_seq_mod_tb;
  localparam int INT_W = 12, FRAC_W = 16, MIN_RATIO = 12;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, cfg_ld = 1'b0;
  logic [1:0] order = 2'd0;
  logic [INT_W-1:0] int_v = '0;
  logic [FRAC_W-1:0] frac_v = '0, den_v = 16'd1;
  logic signed [3:0] offset;
  logic [INT_W:0] div;
  logic valid, viol;

  always #5 clk = ~clk;

  frac_n_seq_mod #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_RATIO(MIN_RATIO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cfg_ld_i(cfg_ld), .order_i(order),
    .int_i(int_v), .frac_i(frac_v), .den_i(den_v), .offset_o(offset),
    .div_o(div), .valid_o(valid), .min_viol_o(viol));

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  longint c_int, c_frac, c_den, cnt, cum;
  int c_ord;
  int hist [64];

  task automatic chk(bit ok, string req, longint act, longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int min_ofs(int o);
    return (o == 0) ? 0 : (o == 1) ? -1 : -3;
  endfunction

  task automatic load(int iv, int fv, int dv, int ov);
    int_v = INT_W'(iv); frac_v = FRAC_W'(fv); den_v = FRAC_W'(dv); order = 2'(ov);
    cfg_ld = 1'b1; en = 1'b1;
    @(posedge clk); #1;
    cfg_ld = 1'b0; en = 1'b0;
    c_int = iv; c_frac = fv; c_den = dv; c_ord = ov; cnt = 0; cum = 0;
    chk(valid == 1'b0, "R8 valid after load", valid, 0);
    chk(offset == 4'sd0, "R8 offset after load", offset, 0);
    chk(viol == ((iv + min_ofs(ov)) < MIN_RATIO), "R10 min ratio flag", viol,
        (iv + min_ofs(ov)) < MIN_RATIO);
  endtask

  task automatic run(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      int o_prev, o;
      longint e, d;
      o_prev = int'(offset);
      en = gaps ? ($urandom % 4 != 0) : 1'b1;
      @(posedge clk); #1;
      o = int'(offset);
      if (en) begin
        cnt++; cum += o;
        if (cnt <= 64) hist[cnt-1] = o;
        chk(valid == 1'b1, "R7 valid after step", valid, 1);
        chk(longint'(div) == c_int + o, "R9 div value", div, c_int + o);
        if (c_ord == 0) begin
          e = (cnt * c_frac) / c_den - ((cnt - 1) * c_frac) / c_den;
          chk(o == e, "R2 first-order offset", o, e);
        end else begin
          if (c_ord == 1) chk(o >= -1 && o <= 2, "R4 second-order span", o, 0);
          else            chk(o >= -3 && o <= 4, "R5 third-order span", o, 0);
          d = c_den * cum - cnt * c_frac;
          chk(d <= 2 * c_den && d >= -2 * c_den, "R6 mean drift", d, 0);
        end
      end else begin
        chk(valid == 1'b0, "R7 valid idle", valid, 0);
        chk(o == o_prev, "R7 offset held", o, o_prev);
      end
    end
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(valid == 1'b0, "R1 valid in reset", valid, 0);
    chk(offset == 4'sd0, "R1 offset in reset", offset, 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(valid == 1'b0 && offset == 4'sd0, "R1 after release", offset, 0);

    // R3: 900 + 1/5
    load(900, 1, 5, 0);
    run(10, 1'b0);
    begin
      int s;
      s = 0;
      for (int i = 0; i < 5; i++) begin
        s += hist[i];
        chk(hist[i] == hist[i+5], "R3 period five", hist[i+5], hist[i]);
      end
      chk(s == 1, "R3 one 901 per five", s, 1);
    end

    // R7: pause keeps position
    load(900, 3, 7, 0);
    run(60, 1'b1);

    // R10 corners
    load(12, 0, 1, 2);
    load(15, 0, 1, 3);
    load(12, 0, 1, 0);
    load(12, 0, 1, 1);
    load(11, 0, 1, 0);
    load(13, 0, 1, 1);

    // R8: load while enabled restarts sequence
    load(500, 7, 9, 1);
    run(20, 1'b0);
    load(500, 7, 9, 1);
    run(20, 1'b0);

    // edge fractions
    load(300, 0, 17, 2);
    run(30, 1'b0);
    load(300, 16, 17, 2);
    run(100, 1'b0);
    load(300, 65534, 65535, 0);
    run(40, 1'b0);

    for (int k = 0; k < 24; k++) begin
      int dv, fv;
      dv = 2 + int'($urandom % 1000);
      fv = int'($urandom % dv);
      load(20 + int'($urandom % 2000), fv, dv, int'($urandom % 4));
      run(200, 1'b1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule